// File: doc/BRIEF.md
# Autovectoring Interrupt Control Unit

This block is the interrupt glue that sits between a 68000-style processor and its interrupt sources. Six active-low request lines (levels 1 to 6), each gated by an enable bit, and an internal abort request at level 7 are priority-encoded into a three-bit active-low level code for the processor's priority inputs. The abort request comes from a pushbutton. The raw button is synchronised, debounced and edge-detected, and the clean edge sets a latch.

When the processor runs an interrupt acknowledge bus cycle, the unit decodes the function code and the level number on address bits A3..A1. It then pulls exactly one of seven active-low per-level acknowledge strobes low while the address strobe is low. For levels 4 to 7 it also pulls the valid-peripheral line low, so that the processor takes the autovector. The level-7 strobe clears the abort latch.

The function code is also decoded into active-low supervisor and program-space indications, which help with debugging.

Top module: `irq_autovec_ctrl`

## Requirements
- R1: `ipl_n` equals the bitwise inverse of the number of the highest active enabled level (1 to 7). It is 3'b111 when no level is active.
- R2: Bit i of `lvl_en` gates request level i+1 for levels 1 to 6. A cleared bit removes that level from encoding. The level-7 abort request is never masked.
- R3: `abort_btn` (high = pressed) passes a two-flop synchroniser. The debounced level changes only after the synchronised sample has differed from it for DEB_CYCLES consecutive clocks (default 16). Shorter pulses have no effect.
- R4: A rising edge of the debounced level sets the abort latch. With the default parameters this happens at the 19th rising clock edge after the press is first sampled. While set, the latch drives level 7, so `ipl_n` is 3'b000. Holding the button does not set the latch again.
- R5: When `fc` is 3'b111 and `as_n` is low, an `ack_lvl` value n in 1..7 drives only `iack_n[n-1]` low. Bit i of `iack_n` belongs to level i+1. An `ack_lvl` of 0, or any other `fc` value, leaves all of `iack_n` high.
- R6: `vpa_n` is low whenever the acknowledge strobe of level 4, 5, 6 or 7 is low.
- R7: Acknowledges at levels 1, 2 and 3 never drive `vpa_n` low.
- R8: A low level-7 acknowledge at a rising clock edge clears the abort latch at that edge. If a debounced rising edge arrives at the same clock edge, the set wins.
- R9: While `as_n` is low, `super_n` is low exactly when `fc[2]` is 1. `prog_n` is low exactly when `fc[1:0]` is 2'b10.
- R10: While `as_n` is high, `iack_n`, `vpa_n`, `super_n` and `prog_n` are all high. While `rst_n` is low, every output is high and the abort latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_n | input | 6 | Active-low requests, bit i = level i+1 |
| lvl_en | input | 6 | Enables for levels 1 to 6, bit i = level i+1 |
| abort_btn | input | 1 | Raw abort pushbutton, high while pressed |
| fc | input | 3 | Processor function code |
| as_n | input | 1 | Active-low address strobe |
| ack_lvl | input | 3 | Address bits A3..A1 during acknowledge |
| ipl_n | output | 3 | Active-low encoded interrupt level |
| iack_n | output | 7 | Active-low acknowledge strobes, bit i = level i+1 |
| vpa_n | output | 1 | Active-low autovector request |
| super_n | output | 1 | Active-low supervisor access indication |
| prog_n | output | 1 | Active-low program-space access indication |

## Verification
Setting the abort latch and clearing it through the level-7 acknowledge can fall on the same clock edge. The bench provokes this by holding a level-7 acknowledge cycle open while the abort button is pressed and stays pressed through its debounce window, so the debounced rise lands inside a cycle where the clear is already active. The collision is judged by counting the clocks in which `ipl_n` reads 3'b000. Exactly one such clock shows that the set won for one edge and the standing acknowledge removed the request at the next edge. A count of zero means the press was lost, and a longer run means the clear was ignored.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
   localparam int unsigned IRQG_LEVELS = 7;
   localparam int unsigned IRQG_LVL_W  = 3;

   typedef logic [IRQG_LVL_W-1:0] lvl_t;

   typedef struct packed {
      logic super_acc;
      logic prog_acc;
   } fc_status_t;

   function automatic fc_status_t decode_fc(input logic [2:0] code);
      fc_status_t s;
      s.super_acc = code[2];
      s.prog_acc  = (code[1:0] == 2'b10);
      return s;
   endfunction
endpackage

// File: rtl/irqg_debounce.sv
module irqg_debounce #(
   parameter int unsigned STABLE_CYCLES = 16,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise
);
   localparam int unsigned CNT_W = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYCLES - 1);

   generate
      if (STABLE_CYCLES < 2) begin : g_bad_stable
         $error("irqg_debounce: STABLE_CYCLES must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irqg_debounce: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       cnt_q;
   logic                   level_q;
   logic                   level_d1;
   logic                   samp;

   assign samp = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         level_q  <= 1'b0;
         level_d1 <= 1'b0;
      end else begin
         level_d1 <= level_q;
         if (samp != level_q) begin
            if (cnt_q == CNT_MAX) begin
               level_q <= samp;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign level = level_q;
   assign rise  = level_q & ~level_d1;

   // R3: the debounced level moves only once the window has run out
   assert_window_before_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (samp != level_q && cnt_q != CNT_MAX) |=> $stable(level_q));

   // R3: a change always moves toward the synchronised sample
   assert_change_follows_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (samp == level_q) |=> $stable(level_q));
endmodule

// File: rtl/irqg_prio_enc.sv
module irqg_prio_enc #(
   parameter int unsigned LEVELS = 7,
   parameter int unsigned LVL_W  = 3
) (
   input  logic [LEVELS-1:0] req,
   output logic [LVL_W-1:0]  code
);
   generate
      if (LEVELS > (2**LVL_W) - 1) begin : g_bad_width
         $error("irqg_prio_enc: LVL_W too narrow for LEVELS");
      end
   endgenerate

   always_comb begin
      code = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (req[i]) code = LVL_W'(i + 1);
      end
   end
endmodule

// File: rtl/irqg_ack_decode.sv
module irqg_ack_decode #(
   parameter int unsigned       LEVELS       = 7,
   parameter int unsigned       LVL_W        = 3,
   parameter logic [LEVELS-1:0] AUTOVEC_MASK = 7'b1111000,
   parameter logic [2:0]        ACK_FC       = 3'b111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        fc,
   input  logic              as_n,
   input  logic [LVL_W-1:0]  ack_lvl,
   output logic [LEVELS-1:0] iack_n,
   output logic              vpa_n
);
   logic ack_cycle;

   assign ack_cycle = rst_n && !as_n && (fc == ACK_FC);

   genvar g;
   generate
      for (g = 0; g < LEVELS; g++) begin : g_strobe
         assign iack_n[g] = ~(ack_cycle && (ack_lvl == LVL_W'(g + 1)));
      end

      if (AUTOVEC_MASK == '0) begin : g_no_autovec
         assign vpa_n = 1'b1;
      end else begin : g_autovec
         assign vpa_n = ~(|(~iack_n & AUTOVEC_MASK));
      end
   endgenerate

   // R5: at most one acknowledge strobe at a time
   assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~iack_n));

   // R10: idle bus keeps every strobe high
   assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (&iack_n && vpa_n));

   // R6: autovector request only alongside an autovectored level
   assert_vpa_has_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !vpa_n |-> |(~iack_n & AUTOVEC_MASK));

   // R7: vectored levels never raise the autovector request
   assert_vectored_no_vpa_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~iack_n & ~AUTOVEC_MASK)) |-> vpa_n);
endmodule

// File: rtl/irq_autovec_ctrl.sv
module irq_autovec_ctrl
   import irqg_pkg::*;
#(
   parameter int unsigned                DEB_CYCLES   = 16,
   parameter int unsigned                SYNC_STAGES  = 2,
   parameter logic [IRQG_LEVELS-1:0]     AUTOVEC_MASK = 7'b1111000,
   parameter logic [2:0]                 ACK_FC       = 3'b111
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IRQG_LEVELS-2:0] irq_n,
   input  logic [IRQG_LEVELS-2:0] lvl_en,
   input  logic                   abort_btn,
   input  logic [2:0]             fc,
   input  logic                   as_n,
   input  logic [IRQG_LVL_W-1:0]  ack_lvl,
   output logic [IRQG_LVL_W-1:0]  ipl_n,
   output logic [IRQG_LEVELS-1:0] iack_n,
   output logic                   vpa_n,
   output logic                   super_n,
   output logic                   prog_n
);
   localparam int unsigned TOP_IDX = IRQG_LEVELS - 1;

   generate
      if (!AUTOVEC_MASK[TOP_IDX]) begin : g_bad_mask
         $error("irq_autovec_ctrl: the abort level must be autovectored");
      end
   endgenerate

   logic             deb_level;
   logic             deb_rise;
   logic             abort_q;
   logic [TOP_IDX:0] req_vec;
   lvl_t             enc_lvl;
   fc_status_t       fc_stat;

   irqg_debounce #(
      .STABLE_CYCLES (DEB_CYCLES),
      .SYNC_STAGES   (SYNC_STAGES)
   ) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (abort_btn),
      .level (deb_level),
      .rise  (deb_rise)
   );

   irqg_ack_decode #(
      .LEVELS       (IRQG_LEVELS),
      .LVL_W        (IRQG_LVL_W),
      .AUTOVEC_MASK (AUTOVEC_MASK),
      .ACK_FC       (ACK_FC)
   ) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .fc      (fc),
      .as_n    (as_n),
      .ack_lvl (ack_lvl),
      .iack_n  (iack_n),
      .vpa_n   (vpa_n)
   );

   // abort latch: data tied high, set by clean edge, cleared by its acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_q <= 1'b0;
      end else if (deb_rise) begin
         abort_q <= 1'b1;
      end else if (!iack_n[TOP_IDX]) begin
         abort_q <= 1'b0;
      end
   end

   assign req_vec = {abort_q, ~irq_n & lvl_en};

   irqg_prio_enc #(
      .LEVELS (IRQG_LEVELS),
      .LVL_W  (IRQG_LVL_W)
   ) u_enc (
      .req  (req_vec),
      .code (enc_lvl)
   );

   assign ipl_n   = rst_n ? ~enc_lvl : '1;
   assign fc_stat = decode_fc(fc);
   assign super_n = ~(rst_n && !as_n && fc_stat.super_acc);
   assign prog_n  = ~(rst_n && !as_n && fc_stat.prog_acc);

   // R4: a set latch always presents the top level
   assert_abort_top_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      abort_q |-> (ipl_n == '0));

   // R8: level-7 acknowledge clears the latch when no new edge competes
   assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!iack_n[TOP_IDX] && !deb_rise) |=> !abort_q);

   // R8: a debounced edge sets the latch even against a clear
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      deb_rise |=> abort_q);

   // R4: latch only rises on a debounced edge
   assert_rise_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_q) |-> $past(deb_rise));

   // R9: status strobes silent with the bus idle
   assert_status_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (super_n && prog_n));
endmodule

// File: tb/irq_autovec_ctrl_tb.sv
module irq_autovec_ctrl_tb;
   localparam int DEB = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] irq_n;
   logic [5:0] lvl_en;
   logic       abort_btn;
   logic [2:0] fc;
   logic       as_n;
   logic [2:0] ack_lvl;
   logic [2:0] ipl_n;
   logic [6:0] iack_n;
   logic       vpa_n;
   logic       super_n;
   logic       prog_n;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   irq_autovec_ctrl #(.DEB_CYCLES(DEB)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .lvl_en(lvl_en),
      .abort_btn(abort_btn), .fc(fc), .as_n(as_n), .ack_lvl(ack_lvl),
      .ipl_n(ipl_n), .iack_n(iack_n), .vpa_n(vpa_n),
      .super_n(super_n), .prog_n(prog_n)
   );

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_ipl(input logic [5:0] rq_n, input logic [5:0] en,
                                          input bit abort);
      int top = 0;
      for (int i = 0; i < 6; i++) if (!rq_n[i] && en[i]) top = i + 1;
      if (abort) top = 7;
      return ~3'(top);
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_idle();
      as_n = 1'b1; fc = 3'b000; ack_lvl = 3'd0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; irq_n = 6'h00; lvl_en = 6'h3f; abort_btn = 1'b0;
      as_n = 1'b0; fc = 3'b111; ack_lvl = 3'd7;
      step(3); #1;
      check("R10 reset ipl", ipl_n, 3'b111);
      check("R10 reset iack", iack_n, 7'h7f);
      check("R10 reset vpa", vpa_n, 1);
      check("R10 reset status", {super_n, prog_n}, 2'b11);
      bus_idle(); irq_n = 6'h3f;
      @(negedge clk); rst_n = 1'b1;
      step(2); #1;
      check("R1 idle ipl", ipl_n, 3'b111);
   endtask

   task automatic t_priority();
      logic [5:0] pats [5] = '{6'h3f, 6'h3b, 6'h2d, 6'h00, 6'h3e};
      lvl_en = 6'h3f;
      foreach (pats[k]) begin
         @(negedge clk); irq_n = pats[k]; #1;
         check("R1 priority", ipl_n, exp_ipl(pats[k], lvl_en, 0));
      end
   endtask

   task automatic t_mask();
      @(negedge clk); irq_n = 6'h00; lvl_en = 6'h0f; #1;
      check("R2 mask upper", ipl_n, 3'b011);
      @(negedge clk); lvl_en = 6'h00; #1;
      check("R2 mask all", ipl_n, 3'b111);
      @(negedge clk); irq_n = 6'h35; lvl_en = 6'h3d; #1;
      check("R2 mixed", ipl_n, exp_ipl(6'h35, 6'h3d, 0));
      @(negedge clk); irq_n = 6'h3f; lvl_en = 6'h3f;
   endtask

   task automatic t_ack_decode();
      for (int l = 0; l < 8; l++) begin
         @(negedge clk); fc = 3'b111; as_n = 1'b0; ack_lvl = 3'(l); #1;
         check("R5 strobe", iack_n, (l == 0) ? 7'h7f : (~(7'h01 << (l - 1)) & 7'h7f));
         if (l >= 4) check("R6 vpa autovec", vpa_n, 0);
         else        check("R7 vpa vectored", vpa_n, 1);
      end
      @(negedge clk); fc = 3'b101; ack_lvl = 3'd5; #1;
      check("R5 wrong fc", iack_n, 7'h7f);
      check("R6 wrong fc vpa", vpa_n, 1);
      @(negedge clk); fc = 3'b111; as_n = 1'b1; #1;
      check("R10 strobe idle", {iack_n, vpa_n}, 8'hff);
      @(negedge clk); bus_idle();
   endtask

   task automatic t_status();
      for (int f = 0; f < 8; f++) begin
         @(negedge clk); fc = 3'(f); as_n = 1'b0; ack_lvl = 3'd0; #1;
         check("R9 super", super_n, (f >= 4) ? 0 : 1);
         check("R9 prog", prog_n, ((f & 3) == 2) ? 0 : 1);
      end
      @(negedge clk); fc = 3'b110; as_n = 1'b1; #1;
      check("R10 status idle", {super_n, prog_n}, 2'b11);
      @(negedge clk); bus_idle();
   endtask

   task automatic t_glitch();
      @(negedge clk); abort_btn = 1'b1;
      step(DEB / 2); abort_btn = 1'b0;
      step(3 * DEB); #1;
      check("R3 short pulse ignored", ipl_n, 3'b111);
   endtask

   task automatic t_abort();
      @(negedge clk); abort_btn = 1'b1;
      step(DEB + 1); #1;
      check("R3 still debouncing", ipl_n, 3'b111);
      step(3); #1;
      check("R4 abort level", ipl_n, 3'b000);
      @(negedge clk); lvl_en = 6'h00; irq_n = 6'h00; #1;
      check("R2 level 7 unmasked", ipl_n, 3'b000);
      @(negedge clk); fc = 3'b111; as_n = 1'b0; ack_lvl = 3'd7; #1;
      check("R5 ack7 strobe", iack_n, 7'h3f);
      check("R6 ack7 vpa", vpa_n, 0);
      @(negedge clk); bus_idle(); #1;
      check("R8 ack clears", ipl_n, 3'b111);
      step(3 * DEB); #1;
      check("R4 held button no reset", ipl_n, 3'b111);
      @(negedge clk); abort_btn = 1'b0; lvl_en = 6'h3f; irq_n = 6'h3f;
      step(DEB + 8);
   endtask

   task automatic t_collide();
      int hits = 0;
      @(negedge clk); fc = 3'b111; as_n = 1'b0; ack_lvl = 3'd7; abort_btn = 1'b1;
      for (int c = 0; c < 3 * DEB; c++) begin
         @(negedge clk); #1;
         if (ipl_n == 3'b000) hits++;
      end
      check("R8 set wins one cycle", hits, 1);
      @(negedge clk); bus_idle(); abort_btn = 1'b0; #1;
      check("R8 cleared after collide", ipl_n, 3'b111);
      step(DEB + 8);
   endtask

   initial begin
      t_reset();
      t_priority();
      t_mask();
      t_ack_decode();
      t_status();
      t_glitch();
      t_abort();
      t_collide();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule